// File: doc/BRIEF.md
# Debug Halt/Restart Run Control

This block sits in a processor debug unit between the debugger's register port and the core. A debugger writes a control word to ask the core to stop in debug state or to resume. Each request is turned into a level toward the core, and that level stays up until the core's state actually changes. A request that would move the core into the state it already holds is dropped. The same control word carries two write-one-to-clear strobes. These reset sticky fields held in a companion status word.

The status word is readable through the same port. The debugger polls it to see whether the core is halted and whether it has completed a restart. It also shows the sticky exception field and the sticky pipeline-advance flag, which the core sets with event pulses. All outputs, including read data, are registered. Read data appears one clock after the address is presented.

Top module: `dbg_runctl`

## Requirements
- R1: After a synchronous reset, halt_req and restart_req are low, and the whole status word reads as zero while core_in_debug is low.
- R2: A write to the control address with bit 0 set, while core_in_debug is low, raises halt_req from the next clock. halt_req stays high until the first clock edge at which core_in_debug is high, and it is low after that edge.
- R3: A control write with bit 0 set, made while core_in_debug is high, leaves halt_req low.
- R4: A control write with bit 1 set, while core_in_debug is high, raises restart_req from the next clock. restart_req stays high until the first clock edge at which core_in_debug is low, and it is low after that edge.
- R5: A control write with bit 1 set, made while core_in_debug is low, leaves restart_req low and does not change status bit 1.
- R6: A read of the control address returns zero in every bit, even while a request is pending.
- R7: A control write with bit 2 set clears status bits [8:6], the sticky exception field, to 000.
- R8: A control write with bit 3 set clears status bit 25, the sticky pipeline-advance flag, to 0.
- R9: A sticky set pulse (exc_set bit i sets status bit 6+i; pipe_adv_set sets bit 25) beats a clear write in the same cycle. The bit being set ends up 1.
- R10: Status bit 0 shows core_in_debug as sampled at the previous clock edge. Status bit 1 clears when a restart request is accepted and sets on a core_restarted pulse.
- R11: A control write with bits 0 and 1 both set starts only the request that is legal for the current core state.
- R12: Control bits [31:4] and any write to the status address have no effect. Status bits other than 0, 1, [8:6] and 25 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address for read and write (control 2, status 1) |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data for the address of the previous cycle |
| core_in_debug | input | 1 | Core is in debug state |
| core_restarted | input | 1 | One-cycle pulse when the core leaves debug state |
| exc_set | input | EXC_W | Sticky exception set pulses |
| pipe_adv_set | input | 1 | Sticky pipeline-advance set pulse |
| halt_req | output | 1 | Held request to enter debug state |
| restart_req | output | 1 | Held request to leave debug state |

## Verification
The checker watches several things on every clock. It checks that each request holds until the core reaches the target state and drops afterwards, and that a request is never raised when the core is already in that state. It also checks that the two requests are never high together, that control reads return zero, that a set pulse always lands in the sticky bits, and that the halted bit tracks the core. Some behaviours need ordered sequences and only the bench scenarios show them. These are the accept-then-clear life of the restarted bit, a set pulse competing with a clear for a neighbouring bit, the lack of effect of reserved bits and of status-address writes, and the combined halt-plus-restart write in each core state.

// File: rtl/dbg_runctl_pkg.sv
package dbg_runctl_pkg;
  // control word bit positions (software visible)
  localparam int CTL_HALT_BIT    = 0;
  localparam int CTL_RESTART_BIT = 1;
  localparam int CTL_CLR_EXC_BIT = 2;
  localparam int CTL_CLR_ADV_BIT = 3;
  localparam int CTL_USED_W      = 4;
  // status word bit positions
  localparam int STS_HALTED_BIT  = 0;
  localparam int STS_RESTART_BIT = 1;
  localparam int STS_EXC_LSB     = 6;
  localparam int STS_ADV_BIT     = 25;
  localparam int STS_MIN_W       = STS_ADV_BIT + 1;
  // width of the sticky exception field
  localparam int EXC_W           = 3;
endpackage

// File: rtl/dbg_req_latch.sv
// Held request toward the core; TARGET_DEBUG selects which core state
// completes (and forbids) the request.
module dbg_req_latch #(
  parameter bit TARGET_DEBUG = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic core_in_debug,
  output logic accept,
  output logic req
);
  logic at_target;

  assign at_target = (core_in_debug == TARGET_DEBUG);
  assign accept    = wr_hit && !at_target;

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
    end else if (at_target) begin
      req <= 1'b0;
    end else if (accept) begin
      req <= 1'b1;
    end
  end
endmodule

// File: rtl/dbg_sticky_bank.sv
// Bank of sticky flags: a set pulse wins over a clear strobe.
module dbg_sticky_bank #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] flags
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        flags[i] <= 1'b0;
      end else if (set_i[i]) begin
        flags[i] <= 1'b1;
      end else if (clr_i) begin
        flags[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbg_runctl.sv
module dbg_runctl
  import dbg_runctl_pkg::*;
#(
  parameter int                DATA_W = 32,
  parameter int                ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STS_ADDR = 1,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              core_in_debug,
  input  logic              core_restarted,
  input  logic [EXC_W-1:0]  exc_set,
  input  logic              pipe_adv_set,
  output logic              halt_req,
  output logic              restart_req
);
  logic ctl_wr;
  logic halt_hit, restart_hit, clr_exc, clr_adv;
  logic halt_acc, restart_acc;
  logic halted_q, restarted_q;
  logic [EXC_W-1:0] exc_q;
  logic [0:0]       adv_q;
  logic [DATA_W-1:0] sts_word;
  logic unused_rsvd;

  assign ctl_wr      = wr_en && (addr == CTL_ADDR);
  assign halt_hit    = ctl_wr && wr_data[CTL_HALT_BIT];
  assign restart_hit = ctl_wr && wr_data[CTL_RESTART_BIT];
  assign clr_exc     = ctl_wr && wr_data[CTL_CLR_EXC_BIT];
  assign clr_adv     = ctl_wr && wr_data[CTL_CLR_ADV_BIT];
  assign unused_rsvd = ^wr_data[DATA_W-1:CTL_USED_W];

  dbg_req_latch #(.TARGET_DEBUG(1'b1)) u_halt (
    .clk(clk), .rst(rst), .wr_hit(halt_hit), .core_in_debug(core_in_debug),
    .accept(halt_acc), .req(halt_req)
  );

  dbg_req_latch #(.TARGET_DEBUG(1'b0)) u_restart (
    .clk(clk), .rst(rst), .wr_hit(restart_hit), .core_in_debug(core_in_debug),
    .accept(restart_acc), .req(restart_req)
  );

  dbg_sticky_bank #(.W(EXC_W)) u_exc (
    .clk(clk), .rst(rst), .set_i(exc_set), .clr_i(clr_exc), .flags(exc_q)
  );

  dbg_sticky_bank #(.W(1)) u_adv (
    .clk(clk), .rst(rst), .set_i(pipe_adv_set), .clr_i(clr_adv), .flags(adv_q)
  );

  // halted mirror and restarted flag; the pulse wins over an acceptance
  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q    <= 1'b0;
      restarted_q <= 1'b0;
    end else begin
      halted_q <= core_in_debug;
      if (core_restarted) begin
        restarted_q <= 1'b1;
      end else if (restart_acc) begin
        restarted_q <= 1'b0;
      end
    end
  end

  always_comb begin
    sts_word                                   = '0;
    sts_word[STS_HALTED_BIT]                   = halted_q;
    sts_word[STS_RESTART_BIT]                  = restarted_q;
    sts_word[STS_EXC_LSB +: EXC_W]             = exc_q;
    sts_word[STS_ADV_BIT]                      = adv_q[0];
  end

  // registered read port; control reads as zero
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (addr == STS_ADDR) begin
      rd_data <= sts_word;
    end else begin
      rd_data <= '0;
    end
  end

  logic unused_acc;
  assign unused_acc = halt_acc;
endmodule

// File: rtl/dbg_runctl_chk.sv
module dbg_runctl_chk
  import dbg_runctl_pkg::*;
#(
  parameter int                DATA_W = 32,
  parameter int                ADDR_W = 4,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              core_in_debug,
  input logic [EXC_W-1:0]  exc_set,
  input logic              pipe_adv_set,
  input logic              halt_req,
  input logic              restart_req,
  input logic [EXC_W-1:0]  sticky_exc,
  input logic [0:0]        sticky_adv,
  input logic              halted_flag
);
  logic unused_bits;
  assign unused_bits = ^wr_data[DATA_W-1:CTL_USED_W] ^ ^wr_data[1:0];

  // R2
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (halt_req && !core_in_debug) |=> halt_req);
  // R2
  halt_drop_chk: assert property (@(posedge clk) disable iff (rst)
    core_in_debug |=> !halt_req);
  // R3
  halt_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (core_in_debug && !halt_req) |=> !halt_req);
  // R4
  restart_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (restart_req && core_in_debug) |=> restart_req);
  // R5
  restart_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !core_in_debug |=> !restart_req);
  // R11
  req_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(halt_req && restart_req));
  // R6
  ctl_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (addr == CTL_ADDR) |=> (rd_data == '0));
  // R7
  exc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CTL_ADDR && wr_data[CTL_CLR_EXC_BIT] && exc_set == '0)
      |=> (sticky_exc == '0));
  // R8
  adv_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CTL_ADDR && wr_data[CTL_CLR_ADV_BIT] && !pipe_adv_set)
      |=> !sticky_adv[0]);
  // R9
  adv_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    pipe_adv_set |=> sticky_adv[0]);
  // R9
  exc_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_set != '0) |=> ((sticky_exc & $past(exc_set)) == $past(exc_set)));
  // R10
  halted_track_chk: assert property (@(posedge clk) disable iff (rst)
    core_in_debug |=> halted_flag);
endmodule

bind dbg_runctl dbg_runctl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_data(rd_data), .core_in_debug(core_in_debug), .exc_set(exc_set),
  .pipe_adv_set(pipe_adv_set), .halt_req(halt_req), .restart_req(restart_req),
  .sticky_exc(exc_q), .sticky_adv(adv_q), .halted_flag(halted_q)
);

// File: tb/dbg_runctl_tb.sv
module dbg_runctl_tb;
  localparam logic [3:0] STS = 4'd1;
  localparam logic [3:0] CTL = 4'd2;
  localparam int NV = 13;
  // {wr, ctl[3:0], in_debug, exp_halt, exp_restart}
  localparam logic [7:0] VEC [NV] = '{
    8'h8A, // R2 halt accepted
    8'h02, // R2 held
    8'h02, // R2 held
    8'h04, // R2 dropped on entry
    8'h8C, // R3 halt ignored in debug
    8'h95, // R4 restart accepted
    8'h05, // R4 held
    8'h00, // R4 dropped on exit
    8'h90, // R5 restart ignored outside debug
    8'h9A, // R11 both bits, only halt
    8'h04, // R2 entry
    8'h9D, // R11 both bits, only restart
    8'h00  // R4 exit
  };

  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0;
  logic [3:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        core_in_debug = 0;
  logic        core_restarted = 0;
  logic [2:0]  exc_set = '0;
  logic        pipe_adv_set = 0;
  logic        halt_req, restart_req;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  dbg_runctl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .core_in_debug(core_in_debug),
    .core_restarted(core_restarted), .exc_set(exc_set),
    .pipe_adv_set(pipe_adv_set), .halt_req(halt_req), .restart_req(restart_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wr_data = d;
    tick();
    wr_en = 0; wr_data = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    tick();
    d = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    wr_en = 1; addr = CTL; wr_data = 32'h3;
    tick(); tick();
    rst = 0; wr_en = 0; wr_data = '0;
    // R1 reset state
    check("R1 halt_req", {31'b0, halt_req}, 32'h0);
    check("R1 restart_req", {31'b0, restart_req}, 32'h0);
    rd(STS, v);
    check("R1 status", v, 32'h0);

    // table walk: R2/R3/R4/R5/R11
    for (int i = 0; i < NV; i++) begin
      wr_en = VEC[i][7]; addr = CTL;
      wr_data = {28'h0, VEC[i][6:3]};
      core_in_debug = VEC[i][2];
      tick();
      wr_en = 0; wr_data = '0;
      check($sformatf("R2/R3/R4/R5/R11 vec %0d halt", i), {31'b0, halt_req}, {31'b0, VEC[i][1]});
      check($sformatf("R2/R3/R4/R5/R11 vec %0d restart", i), {31'b0, restart_req}, {31'b0, VEC[i][0]});
    end

    // R6 control reads zero with halt pending
    wr(CTL, 32'h1);
    check("R6 halt pending", {31'b0, halt_req}, 32'h1);
    rd(CTL, v);
    check("R6 control read", v, 32'h0);
    core_in_debug = 1;
    tick();
    rd(STS, v);
    check("R10 halted bit", v, 32'h1);

    // R10 restarted flag: accept clears, pulse sets
    wr(CTL, 32'h2);
    core_in_debug = 0; core_restarted = 1;
    tick();
    core_restarted = 0;
    rd(STS, v);
    check("R10 restarted set", v, 32'h2);
    wr(CTL, 32'h2);
    rd(STS, v);
    check("R5 restarted kept", v, 32'h2);
    core_in_debug = 1;
    tick();
    wr(CTL, 32'h2);
    rd(STS, v);
    check("R10 restarted cleared", v, 32'h1);
    core_in_debug = 0;
    tick();

    // sticky bits
    exc_set = 3'b101; pipe_adv_set = 1;
    tick();
    exc_set = '0; pipe_adv_set = 0;
    rd(STS, v);
    check("R9 sticky set", v, 32'h0200_0140);
    wr(CTL, 32'h4);
    rd(STS, v);
    check("R7 exc clear", v, 32'h0200_0000);
    wr(CTL, 32'h8);
    rd(STS, v);
    check("R8 adv clear", v, 32'h0);
    exc_set = 3'b001;
    tick();
    exc_set = 3'b010; pipe_adv_set = 1;
    wr(CTL, 32'hC);
    exc_set = '0; pipe_adv_set = 0;
    rd(STS, v);
    check("R9 set beats clear", v, 32'h0200_0080);

    // R12 reserved bits and status writes
    wr(CTL, 32'hFFFF_FFF0);
    check("R12 no halt", {31'b0, halt_req}, 32'h0);
    wr(STS, 32'hFFFF_FFFF);
    check("R12 no halt on status write", {31'b0, halt_req}, 32'h0);
    rd(STS, v);
    check("R12 status unchanged", v, 32'h0200_0080);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule